// File: doc/BRIEF.md
# SPI Register-Access Target

This block is a serial target that lets a host processor read and write a space of 128 eight-bit control registers over a four-wire SPI link. The host drives the serial clock, the active-low select, and the data line into the target. The target returns data on its own output line. Every link pin is oversampled by the system clock through a synchronizer, so the serial clock must run several times slower than the system clock. On the register side there is an address, a write-data bus and a one-cycle write strobe, plus a combinational read-data input from the register file.

The link runs with the clock idling low and with second-edge sampling. The host launches MOSI on each rising SCLK edge and the target samples it on the following falling edge. The target launches MISO on rising edges in the same way. After select falls, the first eight bits form the command, sent most significant bit first. The upper seven bits of the command are the register address. The lowest bit is the direction: 1 means read and 0 means write.

- On a write, the next eight bits are the data, and they are committed with a single strobe.
- On a read, the addressed register is fetched once and shifted out over the next eight clocks.

After one access, the target ignores the link until select rises and falls again. If select rises partway through an access, the partial access is dropped.

Controller states:
- `ST_IDLE`: select is high. MISO is released.
- `ST_CMD`: collecting the command.
- `ST_FETCH`: one cycle in which the read value is captured.
- `ST_RDATA`: shifting out the read value.
- `ST_WDATA`: collecting the write data.
- `ST_COMMIT`: the write-strobe cycle.
- `ST_HOLD`: the access is done and the target waits for select to rise.

Transitions:
- Select high moves every state to `ST_IDLE`.
- A select falling edge moves `ST_IDLE` to `ST_CMD`.
- When the command completes, `ST_CMD` moves to `ST_FETCH` if the direction bit is 1, and to `ST_WDATA` if it is 0.
- `ST_FETCH` moves to `ST_RDATA` on the next cycle.
- When the eighth falling edge of the data byte arrives, `ST_RDATA` moves to `ST_HOLD` and `ST_WDATA` moves to `ST_COMMIT`.
- `ST_COMMIT` moves to `ST_HOLD` on the next cycle.

Top module: `spi_reg_target`

## Requirements
- R1: After reset, `spi_miso_oe` and `reg_we` are both low.
- R2: While select is high, `spi_miso_oe` is low. A few system clocks after select falls, `spi_miso_oe` is high, and it stays high until select rises.
- R3: MOSI is sampled on falling SCLK edges. MISO changes only after a rising SCLK edge, so MISO holds steady from a falling edge until the next rising edge.
- R4: The command is the first 8 bits after select falls, most significant bit first. Bits 7..1 of the command are the register address (0 to 127). Bit 0 is the direction: 1 selects a read and 0 selects a write.
- R5: On a write command, the next 8 bits, most significant bit first, form the data. `reg_we` pulses high for exactly one system clock after the eighth data bit is sampled. During that pulse, `reg_addr` carries the commanded address and `reg_wdata` carries the data.
- R6: On a read command, the addressed register value is captured once, right after the command completes. It is shifted out on MISO over the next 8 SCLK periods, most significant bit first, with each bit launched on a rising edge.
- R7: A read access never asserts `reg_we`.
- R8: If select rises before an access completes, the partial access is dropped: there is no write strobe, and the next frame decodes a new command.
- R9: After one access completes, further SCLK activity while select stays low is ignored: there is no strobe, and MISO stays 0 until select rises and falls again.
- R10: While the command byte is being shifted in, MISO is driven 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the link |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from the host; idles low |
| spi_ss_n | input | 1 | Active-low frame select from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output enable for the MISO pad; low means released |
| reg_addr | output | 7 | Register address for the current access |
| reg_wdata | output | 8 | Write data, valid while `reg_we` is high |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Combinational read data for `reg_addr` |

## Verification
The assertions assume that SCLK is low whenever select changes. They also assume that each SCLK level and each MOSI value is held for well over the synchronizer depth plus one system clock, so that every edge is seen exactly once and MOSI is stable when a falling edge is detected. They further assume that the register file returns `reg_rdata` in the same cycle as `reg_addr` changes. The bench holds each SCLK phase for 8 system clocks. It moves MOSI only together with a rising edge, and it changes select only while SCLK is low. Its register model answers reads combinationally.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_FETCH,
        ST_RDATA,
        ST_WDATA,
        ST_COMMIT,
        ST_HOLD
    } ctrl_state_e;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    generate
        for (genvar gi = 0; gi < W; gi++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= {STAGES{RST_VAL[gi]}};
                end else begin
                    chain <= {chain[STAGES-2:0], din[gi]};
                end
            end
            assign dout[gi] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
    parameter int DATA_W = 8,
    parameter int SH_W   = 8,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idle,
    input  logic              sample_en,
    input  logic              byte_done,
    input  logic              rx_en,
    input  logic              launch_en,
    input  logic              tx_load,
    input  logic              tx_active,
    input  logic [DATA_W-1:0] load_val,
    input  logic              mosi_s,
    output logic [SH_W-1:0]   rx_q,
    output logic [SH_W-1:0]   rx_next,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic              miso_q
);

    logic [DATA_W-1:0] tx_q;

    assign rx_next = {rx_q[SH_W-2:0], mosi_s};

    // bit counter over falling edges of the current byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
        end else if (idle) begin
            bit_cnt <= '0;
        end else if (sample_en) begin
            bit_cnt <= byte_done ? '0 : bit_cnt + CNT_W'(1);
        end
    end

    // receive shifter, MSB first
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (sample_en && rx_en) begin
            rx_q <= rx_next;
        end
    end

    // transmit shifter, launched on rising SCLK
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q   <= '0;
            miso_q <= 1'b0;
        end else if (idle) begin
            miso_q <= 1'b0;
        end else if (tx_load) begin
            tx_q <= load_val;
        end else if (launch_en) begin
            if (tx_active) begin
                miso_q <= tx_q[DATA_W-1];
                tx_q   <= {tx_q[DATA_W-2:0], 1'b0};
            end else begin
                miso_q <= 1'b0;
            end
        end
    end

    p_miso_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(miso_q) |-> ($past(launch_en) || $past(idle)));

    p_miso_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(miso_q) |-> $past(tx_active));

endmodule

// File: rtl/spi_ctrl_fsm.sv
module spi_ctrl_fsm
    import spi_regif_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8,
    parameter int SH_W   = 8,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ss_s,
    input  logic              ss_fall,
    input  logic              sclk_fall,
    input  logic [CNT_W-1:0]  bit_cnt,
    input  logic [SH_W-1:0]   rx_next,
    output logic              idle,
    output logic              sample_en,
    output logic              byte_done,
    output logic              rx_en,
    output logic              tx_load,
    output logic              tx_active,
    output logic              miso_oe,
    output logic              reg_we,
    output logic [ADDR_W-1:0] reg_addr
);

    localparam int               CMD_W     = ADDR_W + 1;
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

    ctrl_state_e state_q, state_d;
    logic        count_en;
    logic        read_q;
    logic [CNT_W-1:0] last_idx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // command capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_addr <= '0;
            read_q   <= 1'b0;
        end else if (state_q == ST_CMD && byte_done) begin
            reg_addr <= rx_next[CMD_W-1:1];
            read_q   <= rx_next[0];
        end
    end

    assign last_idx  = (state_q == ST_CMD) ? CMD_LAST : DATA_LAST;
    assign sample_en = sclk_fall && count_en;
    assign byte_done = sample_en && (bit_cnt == last_idx);

    // next state
    always_comb begin
        state_d = state_q;
        if (ss_s) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   if (ss_fall) state_d = ST_CMD;
                ST_CMD:    if (byte_done) state_d = rx_next[0] ? ST_FETCH : ST_WDATA;
                ST_FETCH:  state_d = ST_RDATA;
                ST_RDATA:  if (byte_done) state_d = ST_HOLD;
                ST_WDATA:  if (byte_done) state_d = ST_COMMIT;
                ST_COMMIT: state_d = ST_HOLD;
                ST_HOLD:   state_d = ST_HOLD;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // outputs decoded from state
    always_comb begin
        idle      = 1'b0;
        count_en  = 1'b0;
        rx_en     = 1'b0;
        tx_load   = 1'b0;
        tx_active = 1'b0;
        reg_we    = 1'b0;
        miso_oe   = 1'b1;
        unique case (state_q)
            ST_IDLE:   begin idle = 1'b1; miso_oe = 1'b0; end
            ST_CMD:    begin count_en = 1'b1; rx_en = 1'b1; end
            ST_FETCH:  tx_load = 1'b1;
            ST_RDATA:  begin count_en = 1'b1; tx_active = 1'b1; end
            ST_WDATA:  begin count_en = 1'b1; rx_en = 1'b1; end
            ST_COMMIT: reg_we = 1'b1;
            ST_HOLD:   ;
            default:   begin idle = 1'b1; miso_oe = 1'b0; end
        endcase
    end

    p_we_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    p_read_no_we_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> !read_q);

endmodule

// File: rtl/spi_reg_target.sv
module spi_reg_target #(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_ss_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    input  logic [DATA_W-1:0] reg_rdata
);

    localparam int CMD_W = ADDR_W + 1;
    localparam int SH_W  = (CMD_W > DATA_W) ? CMD_W : DATA_W;
    localparam int CNT_W = $clog2(SH_W);

    logic [2:0] pins_s;
    logic       ss_s, sclk_s, mosi_s;
    logic       ss_d, sclk_d;
    logic       ss_fall, sclk_rise, sclk_fall;

    logic             idle, sample_en, byte_done, rx_en;
    logic             tx_load, tx_active;
    logic [SH_W-1:0]  rx_q, rx_next;
    logic [CNT_W-1:0] bit_cnt;

    spi_pin_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({spi_ss_n, spi_sclk, spi_mosi}),
        .dout  (pins_s)
    );

    assign {ss_s, sclk_s, mosi_s} = pins_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ss_d   <= 1'b1;
            sclk_d <= 1'b0;
        end else begin
            ss_d   <= ss_s;
            sclk_d <= sclk_s;
        end
    end

    assign ss_fall   = ss_d && !ss_s;
    assign sclk_rise = sclk_s && !sclk_d;
    assign sclk_fall = sclk_d && !sclk_s;

    spi_ctrl_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .SH_W   (SH_W),
        .CNT_W  (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ss_s      (ss_s),
        .ss_fall   (ss_fall),
        .sclk_fall (sclk_fall),
        .bit_cnt   (bit_cnt),
        .rx_next   (rx_next),
        .idle      (idle),
        .sample_en (sample_en),
        .byte_done (byte_done),
        .rx_en     (rx_en),
        .tx_load   (tx_load),
        .tx_active (tx_active),
        .miso_oe   (spi_miso_oe),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr)
    );

    spi_shift_unit #(
        .DATA_W (DATA_W),
        .SH_W   (SH_W),
        .CNT_W  (CNT_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .idle      (idle),
        .sample_en (sample_en),
        .byte_done (byte_done),
        .rx_en     (rx_en),
        .launch_en (sclk_rise),
        .tx_load   (tx_load),
        .tx_active (tx_active),
        .load_val  (reg_rdata),
        .mosi_s    (mosi_s),
        .rx_q      (rx_q),
        .rx_next   (rx_next),
        .bit_cnt   (bit_cnt),
        .miso_q    (spi_miso)
    );

    assign reg_wdata = rx_q[DATA_W-1:0];

    p_oe_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_s && $past(ss_s)) |-> !spi_miso_oe);

    p_no_we_after_ss_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ss_s |=> !reg_we);

    p_addr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> $stable(reg_addr));

endmodule

// File: tb/test_spi_reg_target.sv
module test_spi_reg_target;

    localparam int H = 8;

    typedef struct packed {
        logic [6:0] a;
        logic [7:0] d;
    } wr_item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0;
    logic       ss_n = 1'b1;
    logic       mosi = 1'b0;
    logic       miso, miso_oe, reg_we;
    logic [6:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;

    logic [7:0] regs [128];
    logic [7:0] mdl  [128];
    wr_item_t   exp_q [$];

    int n_chk = 0;
    int n_fail = 0;
    int we_count = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    spi_reg_target i_spi_reg_target (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_sclk    (sclk),
        .spi_ss_n    (ss_n),
        .spi_mosi    (mosi),
        .spi_miso    (miso),
        .spi_miso_oe (miso_oe),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_we      (reg_we),
        .reg_rdata   (reg_rdata)
    );

    assign reg_rdata = regs[reg_addr];

    always @(posedge clk) begin
        if (reg_we) regs[reg_addr] <= reg_wdata;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // scoreboard monitor: every strobe must match the next queued write
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && reg_we) begin
                we_count++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected strobe", {25'd0, reg_addr}, 32'hffff);
                end else begin
                    wr_item_t it;
                    it = exp_q.pop_front();
                    check(reg_addr == it.a, "R5 strobe address", {25'd0, reg_addr}, {25'd0, it.a});
                    check(reg_wdata == it.d, "R5 strobe data", {24'd0, reg_wdata}, {24'd0, it.d});
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000 && !done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            finish_run();
        end
    end

    // shift n bits (MSB first); also checks MISO holds across each falling edge (R3)
    task automatic xfer(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = '0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            sclk = 1'b1;
            mosi = tx[7-k];
            wclk(H - 1);
            rx[7-k] = miso;
            wclk(1);
            sclk = 1'b0;
            wclk(3);
            check(miso == rx[7-k], "R3 MISO held after falling edge", {31'd0, miso}, {31'd0, rx[7-k]});
            wclk(H - 3);
        end
    endtask

    task automatic frame_begin();
        @(negedge clk);
        ss_n = 1'b0;
        wclk(H);
    endtask

    task automatic frame_end();
        wclk(H);
        ss_n = 1'b1;
        wclk(2 * H);
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] d);
        logic [7:0] rx;
        wr_item_t it;
        it.a = a;
        it.d = d;
        exp_q.push_back(it);
        mdl[a] = d;
        frame_begin();
        xfer({a, 1'b0}, 8, rx);
        check(rx == 8'h00, "R10 MISO zero in command", {24'd0, rx}, 0);
        xfer(d, 8, rx);
        frame_end();
    endtask

    task automatic do_read(input logic [6:0] a);
        logic [7:0] rx;
        int wc;
        wc = we_count;
        frame_begin();
        xfer({a, 1'b1}, 8, rx);
        check(rx == 8'h00, "R10 MISO zero in command", {24'd0, rx}, 0);
        xfer(8'h00, 8, rx);
        check(rx == mdl[a], "R6 read data", {24'd0, rx}, {24'd0, mdl[a]});
        frame_end();
        check(we_count == wc, "R7 no strobe on read", we_count, wc);
    endtask

    initial begin
        logic [7:0] rx;
        int wc;
        for (int i = 0; i < 128; i++) begin
            regs[i] = 8'(i * 37 + 5);
            mdl[i]  = 8'(i * 37 + 5);
        end
        wclk(5);
        check(miso_oe == 1'b0, "R1 reset oe", {31'd0, miso_oe}, 0);
        check(reg_we == 1'b0, "R1 reset strobe", {31'd0, reg_we}, 0);
        rst_n = 1'b1;
        wclk(5);
        check(miso_oe == 1'b0, "R2 oe low while select high", {31'd0, miso_oe}, 0);

        // R2: enable follows select
        frame_begin();
        check(miso_oe == 1'b1, "R2 oe high in frame", {31'd0, miso_oe}, 1);
        frame_end();
        check(miso_oe == 1'b0, "R2 oe low after frame", {31'd0, miso_oe}, 0);

        // R4, R5: writes at boundary addresses and patterns
        do_write(7'd0, 8'hA5);
        do_write(7'd127, 8'h00);
        do_write(7'h55, 8'hFF);
        do_write(7'h2A, 8'h3C);

        // R4, R6: reads of written and untouched registers
        do_read(7'd0);
        do_read(7'd127);
        do_read(7'h55);
        do_read(7'h2A);
        do_read(7'd9);

        // R8: select rises after 5 data bits of a write
        wc = we_count;
        frame_begin();
        xfer({7'd9, 1'b0}, 8, rx);
        xfer(8'hEE, 5, rx);
        frame_end();
        check(we_count == wc, "R8 partial write dropped", we_count, wc);
        do_read(7'd9);

        // R8: select rises mid-command, then a fresh read decodes cleanly
        frame_begin();
        xfer(8'hFF, 3, rx);
        frame_end();
        do_read(7'h55);

        // R9: extra bytes after a write while select stays low
        wc = we_count;
        exp_q.push_back('{a: 7'd3, d: 8'h11});
        mdl[3] = 8'h11;
        frame_begin();
        xfer({7'd3, 1'b0}, 8, rx);
        xfer(8'h11, 8, rx);
        xfer({7'd3, 1'b0}, 8, rx);
        xfer(8'h99, 8, rx);
        frame_end();
        check(we_count == wc + 1, "R9 single strobe per frame", we_count, wc + 1);
        do_read(7'd3);

        // R9: extra byte after a read returns zeros
        frame_begin();
        xfer({7'd127, 1'b1}, 8, rx);
        xfer(8'h00, 8, rx);
        check(rx == mdl[127], "R6 read before extra byte", {24'd0, rx}, {24'd0, mdl[127]});
        xfer(8'hFF, 8, rx);
        check(rx == 8'h00, "R9 MISO zero after access", {24'd0, rx}, 0);
        frame_end();

        check(exp_q.size() == 0, "R5 all writes strobed", exp_q.size(), 0);
        finish_run();
    end

endmodule